// File: doc/BRIEF.md
# Multichannel DAC Gain/Offset Calibration Core

This block is the digital front end of a multichannel 14-bit voltage-output converter. A host writes transactions made of a channel number, a 2-bit register-select code and a 14-bit word. Depending on the select code, the word lands in that channel's raw input code, its offset trim or its gain trim. The fourth code addresses special-function space, which lies outside this block. Every channel keeps its own three values. After each accepted write to one of them, a single shared multiply-add unit recomputes that channel's corrected code and stores it in a per-channel staging register.

The corrected code is `floor((gain + 2) * input / 16384) + offset - 8192`, clamped to the range 0..16383. A gain trim near full scale gives unity gain, and an offset trim at mid-scale gives zero shift. The staging registers do not drive the outputs directly. An active-low load strobe copies every channel's staged code into the output registers on one clock edge, so all converters update together. A recomputation takes two cycles after the write and shows on a busy flag. Writes that arrive while the flag is high are refused. A load strobe that arrives in that window is held until the staged code is fresh.

Top module: `dac_cal_core`

## Requirements
- R1: After reset every output code is 0, busy and wr_ack are low, every gain trim reads as 0x3FFE and every offset trim as 0x2000, so a later input write of value v alone produces output v.
- R2: The select code addresses the registers: 2'b11 the input code, 2'b10 the offset trim, 2'b01 the gain trim.
- R3: The staged code equals floor((gain+2)*input/16384) + offset - 8192, using the channel's current three values.
- R4: Bit 0 of a written gain word is discarded, and the gain trim always holds it as zero.
- R5: A result above 16383 is clamped to 16383, and a result below 0 is clamped to 0.
- R6: A write with select 2'b00 to a valid channel is acknowledged, changes no register and leaves busy low.
- R7: An accepted write raises wr_ack in the following cycle. When the write has select code 11, 10 or 01, busy is then high for exactly two cycles.
- R8: A write made while busy is high, or one addressed to channel NUM_CH or above, is refused: no wr_ack, and no register changes.
- R9: Outputs change only on a load. A load sampled low at an edge with busy low copies all channels' staged codes, and they are visible in the next cycle.
- R10: A load sampled while busy is high, or in the cycle a computing write is accepted, is held. It is carried out at the first edge with busy low, and it shows the result of that write.
- R11: Channels are independent: a write changes only the addressed channel's staged code, including the last channel NUM_CH-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request, sampled on the rising edge |
| wr_ch | input | CH_W (6) | Channel number of the write |
| wr_sel | input | 2 | Register select: 11 input, 10 offset, 01 gain, 00 special |
| wr_data | input | DW (14) | Write data word |
| wr_ack | output | 1 | High for one cycle after an accepted write |
| busy | output | 1 | Recomputation in progress; writes are refused |
| load_n | input | 1 | Active-low load strobe |
| dac_out | output | NUM_CH*DW (560) | Output codes, channel i at bits [i*14 +: 14] |

## Verification
The correction is exercised with default trims, where the output must equal the input, and with a half gain combined with a positive offset, which exposes rounding by the floor. A gain word of 1 tells a design that keeps bit 0 (giving 2) apart from one that drops it (giving 1). Inputs at both extremes paired with extreme offsets reach both clamps. Timing patterns cover a load held across busy, a write refused during busy, an out-of-range channel, a special-function write, and writes staged without a load, which must leave the outputs untouched.

// File: rtl/dac_cal_pkg.sv
package dac_cal_pkg;
  // register-select codes seen on wr_sel
  localparam logic [1:0] SEL_SFR  = 2'b00;
  localparam logic [1:0] SEL_GAIN = 2'b01;
  localparam logic [1:0] SEL_OFFS = 2'b10;
  localparam logic [1:0] SEL_DATA = 2'b11;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_CALC} cal_state_e;
endpackage

// File: rtl/dac_cal_ram.sv
// One trim bank: RAM-style storage with a synchronous read, plus a
// per-entry written flag so unwritten entries return the reset value.
module dac_cal_ram #(
  parameter int DEPTH = 40,
  parameter int DW    = 14,
  parameter int AW    = 6,
  parameter logic [DW-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] written;
  logic [DW-1:0]    q;
  logic             q_written;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written   <= '0;
      q_written <= 1'b0;
    end else begin
      if (we) written[waddr] <= 1'b1;
      q_written <= written[raddr];
    end
  end

  assign rdata = q_written ? q : INIT;
endmodule

// File: rtl/dac_cal_datapath.sv
// Shared correction unit: one multiplier, offset add, clamp.
module dac_cal_datapath #(
  parameter int DW = 14
) (
  input  logic [DW-1:0] x1,
  input  logic [DW-1:0] gain,
  input  logic [DW-1:0] offs,
  output logic [DW-1:0] x2
);
  localparam int PW = 2*DW + 1;
  localparam int SW = DW + 2;
  localparam logic signed [SW-1:0] ZERO_OFFS = SW'(1 << (DW-1));
  localparam logic signed [SW-1:0] MAX_CODE  = SW'((1 << DW) - 1);

  logic [DW:0]            gain_p2;
  logic [PW-1:0]          prod;
  logic [DW:0]            scaled;
  logic signed [SW-1:0]   sum;

  assign gain_p2 = {1'b0, gain} + (DW+1)'(2);
  assign prod    = PW'(gain_p2) * PW'(x1);
  assign scaled  = prod[PW-1:DW];
  assign sum     = $signed({1'b0, scaled}) + $signed({2'b00, offs}) - ZERO_OFFS;

  always_comb begin
    if (sum < 0)             x2 = '0;
    else if (sum > MAX_CODE) x2 = {DW{1'b1}};
    else                     x2 = sum[DW-1:0];
  end
endmodule

// File: rtl/dac_cal_ctrl.sv
// Write acceptance, recompute sequencing and load hold-off.
module dac_cal_ctrl
  import dac_cal_pkg::*;
#(
  parameter int NUM_CH = 40,
  parameter int CH_W   = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_ch,
  input  logic [1:0]      wr_sel,
  input  logic            load_n,
  output logic            accept,
  output logic            wr_ack,
  output logic            busy,
  output logic [CH_W-1:0] calc_ch,
  output logic            stage_we,
  output logic            do_load,
  output logic            load_pend
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  cal_state_e state;
  logic       start;
  logic       load_req;

  assign busy     = (state != ST_IDLE);
  assign accept   = wr_en && !busy && (wr_ch <= LAST_CH);
  assign start    = accept && (wr_sel != SEL_SFR);
  assign stage_we = (state == ST_CALC);
  assign load_req = !load_n || load_pend;
  assign do_load  = load_req && !busy && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      calc_ch   <= '0;
      wr_ack    <= 1'b0;
      load_pend <= 1'b0;
    end else begin
      wr_ack    <= accept;
      load_pend <= load_req && !do_load;
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_READ;
          calc_ch <= wr_ch;
        end
        ST_READ: state <= ST_CALC;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_cal_core.sv
module dac_cal_core
  import dac_cal_pkg::*;
#(
  parameter int NUM_CH = 40,
  parameter int DW     = 14,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [CH_W-1:0]    wr_ch,
  input  logic [1:0]         wr_sel,
  input  logic [DW-1:0]      wr_data,
  output logic               wr_ack,
  output logic               busy,
  input  logic               load_n,
  output logic [NUM_CH*DW-1:0] dac_out
);
  localparam int NBANK = 3;  // 0 gain, 1 offset, 2 input
  localparam logic [2*NBANK-1:0] BANK_SEL = {SEL_DATA, SEL_OFFS, SEL_GAIN};
  localparam logic [DW-1:0] GAIN_RST = DW'((1 << DW) - 2);
  localparam logic [DW-1:0] OFFS_RST = DW'(1 << (DW-1));
  localparam logic [NBANK*DW-1:0] BANK_INIT = {{DW{1'b0}}, OFFS_RST, GAIN_RST};

  logic            accept;
  logic [CH_W-1:0] calc_ch;
  logic            stage_we;
  logic            do_load;
  logic            load_pend;
  logic [DW-1:0]   bank_q [NBANK];
  logic [DW-1:0]   x2;

  dac_cal_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
    .load_n(load_n), .accept(accept), .wr_ack(wr_ack), .busy(busy),
    .calc_ch(calc_ch), .stage_we(stage_we), .do_load(do_load),
    .load_pend(load_pend)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DW-1:0] wdata;
    if (b == 0) begin : g_gain_mask
      assign wdata = {wr_data[DW-1:1], 1'b0};
    end else begin : g_plain
      assign wdata = wr_data;
    end
    dac_cal_ram #(
      .DEPTH(NUM_CH), .DW(DW), .AW(CH_W), .INIT(BANK_INIT[b*DW +: DW])
    ) u_ram (
      .clk(clk), .rst(rst),
      .we(accept && (wr_sel == BANK_SEL[2*b +: 2])),
      .waddr(wr_ch), .wdata(wdata),
      .raddr(calc_ch), .rdata(bank_q[b])
    );
  end

  dac_cal_datapath #(.DW(DW)) u_dp (
    .x1(bank_q[2]), .gain(bank_q[0]), .offs(bank_q[1]), .x2(x2)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [DW-1:0] staged;
    always_ff @(posedge clk) begin
      if (rst) begin
        staged              <= '0;
        dac_out[i*DW +: DW] <= '0;
      end else begin
        if (stage_we && calc_ch == CH_W'(i)) staged <= x2;
        if (do_load) dac_out[i*DW +: DW] <= staged;
      end
    end
  end
endmodule

// File: rtl/dac_cal_chk.sv
module dac_cal_chk #(
  parameter int NUM_CH = 40,
  parameter int DW     = 14,
  parameter int CH_W   = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [CH_W-1:0]      wr_ch,
  input logic [1:0]           wr_sel,
  input logic                 wr_ack,
  input logic                 busy,
  input logic                 load_n,
  input logic                 load_pend,
  input logic [NUM_CH*DW-1:0] dac_out
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  // R7
  ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ack |-> $past(wr_en));
  // R7
  busy_two_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy);
  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |=> !busy);
  // R6
  sfr_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy && wr_sel == 2'b00 && wr_ch <= LAST_CH) |=> (wr_ack && !busy));
  // R8
  busy_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> !wr_ack);
  // R8
  range_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_ch > LAST_CH) |=> !wr_ack);
  // R9
  no_load_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (load_n && !load_pend) |=> $stable(dac_out));
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(dac_out));
endmodule

bind dac_cal_core dac_cal_chk #(.NUM_CH(NUM_CH), .DW(DW), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
  .wr_ack(wr_ack), .busy(busy), .load_n(load_n), .load_pend(load_pend),
  .dac_out(dac_out)
);

// File: tb/dac_cal_core_tb.sv
`timescale 1ns/1ps
module dac_cal_core_tb;
  localparam int NUM_CH = 40;
  localparam int DW     = 14;
  localparam int CH_W   = 6;
  localparam int OW     = NUM_CH*DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [CH_W-1:0] wr_ch = '0;
  logic [1:0]    wr_sel = 2'b00;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ack;
  logic          busy;
  logic          load_n = 1'b1;
  logic [OW-1:0] dac_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int m_x[NUM_CH];
  int m_g[NUM_CH];
  int m_c[NUM_CH];
  int m_stage[NUM_CH];
  int m_out[NUM_CH];

  logic [OW-1:0] exp_q[$];
  string         tag_q[$];

  always #2.5 clk = ~clk;

  dac_cal_core #(.NUM_CH(NUM_CH), .DW(DW), .CH_W(CH_W)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
    .wr_data(wr_data), .wr_ack(wr_ack), .busy(busy), .load_n(load_n),
    .dac_out(dac_out)
  );

  function automatic int corr(int x, int g, int c);
    int s;
    s = ((g + 2) * x) / 16384 + c - 8192;
    if (s < 0) s = 0;
    if (s > 16383) s = 16383;
    return s;
  endfunction

  function automatic logic [OW-1:0] pack_out();
    logic [OW-1:0] v;
    for (int i = 0; i < NUM_CH; i++) v[i*DW +: DW] = DW'(m_out[i]);
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: one write, checks ack and busy length, updates the model
  task automatic wr(int ch, int sel, int data, string req);
    bit ok, comp;
    int n;
    ok   = (ch < NUM_CH);
    comp = ok && (sel != 0);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = CH_W'(ch); wr_sel = 2'(sel); wr_data = DW'(data);
    @(negedge clk);
    wr_en = 1'b0;
    check({req, " R7 ack"}, int'(wr_ack), int'(ok));
    if (ok) begin
      if (sel == 3) m_x[ch] = data;
      if (sel == 2) m_c[ch] = data;
      if (sel == 1) m_g[ch] = data & 16'h3FFE;
      m_stage[ch] = corr(m_x[ch], m_g[ch], m_c[ch]);
    end
    n = 0;
    while (busy && n < 10) begin
      n++;
      @(negedge clk);
    end
    check({req, " R7 busy cycles"}, n, comp ? 2 : 0);
  endtask

  // driver: one-cycle load, pushes the expected snapshot
  task automatic ld(string req);
    @(negedge clk);
    load_n = 1'b0;
    @(negedge clk);
    load_n = 1'b1;
    for (int i = 0; i < NUM_CH; i++) m_out[i] = m_stage[i];
    exp_q.push_back(pack_out());
    tag_q.push_back(req);
  endtask

  // monitor: compares each expected snapshot with the outputs
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [OW-1:0] e;
      string t;
      int bad;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      bad = 0;
      for (int i = 0; i < NUM_CH; i++) begin
        if (dac_out[i*DW +: DW] !== e[i*DW +: DW]) begin
          bad++;
          $display("FAIL %s ch%0d: actual=%0d expected=%0d", t, i,
                   dac_out[i*DW +: DW], e[i*DW +: DW]);
        end
      end
      checks++;
      if (bad != 0) errors++;
    end
  end

  initial begin
    for (int i = 0; i < NUM_CH; i++) begin
      m_x[i] = 0; m_g[i] = 16'h3FFE; m_c[i] = 16'h2000;
      m_stage[i] = 0; m_out[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset out", int'(dac_out == '0), 1);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset ack", int'(wr_ack), 0);

    // R1 R2 R3: default trims, output equals input
    wr(0, 3, 5000, "R1");
    ld("R1 unity default trims");

    // R3 R9: half gain with offset, staged but not loaded yet
    wr(1, 1, 16'h2000, "R2 gain");
    wr(1, 2, 16'h2000 + 100, "R2 offs");
    wr(1, 3, 10000, "R3");
    check("R9 no load no change", int'(dac_out[1*DW +: DW]), 0);
    ld("R3 half gain plus offset");

    // R4: gain word 1 stored as 0
    wr(2, 1, 1, "R4 gain");
    wr(2, 3, 16383, "R4");
    ld("R4 gain bit0 dropped");

    // R5: clamps
    wr(3, 2, 16'h3FFF, "R5 offs hi");
    wr(3, 3, 16383, "R5 hi");
    wr(4, 2, 0, "R5 offs lo");
    wr(4, 3, 100, "R5 lo");
    ld("R5 clamp high and low");

    // R6: special-function write changes nothing
    wr(0, 0, 16'h1555, "R6");
    ld("R6 special write no effect");

    // R8: refused writes
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 6'd5; wr_sel = 2'b11; wr_data = 14'd700;
    @(negedge clk);
    m_x[5] = 700; m_stage[5] = corr(700, m_g[5], m_c[5]);
    wr_data = 14'd999;  // second write while busy is high
    @(negedge clk);
    wr_en = 1'b0;
    check("R8 busy write ack", int'(wr_ack), 0);
    repeat (3) @(negedge clk);
    wr(45, 3, 1234, "R8 range");
    ld("R8 refused writes no effect");

    // R10: load during busy held until computed
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 6'd6; wr_sel = 2'b11; wr_data = 14'd4321;
    @(negedge clk);
    wr_en = 1'b0; load_n = 1'b0;
    m_x[6] = 4321; m_stage[6] = corr(4321, m_g[6], m_c[6]);
    @(negedge clk);
    load_n = 1'b1;
    check("R10 held while busy", int'(dac_out[6*DW +: DW]), 0);
    @(negedge clk);
    check("R10 held at compute edge", int'(dac_out[6*DW +: DW]), 0);
    @(negedge clk);
    check("R10 applied after busy", int'(dac_out[6*DW +: DW]), 4321);
    for (int i = 0; i < NUM_CH; i++) m_out[i] = m_stage[i];

    // R11: independent channels including the last one
    wr(39, 3, 16000, "R11 last");
    wr(38, 1, 16'h1000, "R11 gain");
    wr(38, 3, 12000, "R11");
    ld("R11 independent channels");

    repeat (4) @(negedge clk);
    check("R9 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule